// File: doc/BRIEF.md
# Six-Channel Shadowed PWM Controller

This block is a register-mapped pulse-width modulator with six independent outputs. Software reaches it over a simple 32-bit register bus. Each channel has three registers: a control word, a period count and a first-phase count. The block counts input clock cycles. For the first-phase count at the start of every period, a channel drives a programmable level, and for the rest of the period it drives the opposite level.

New period and first-phase values are written into shadow registers, and the running waveform does not see them until they are committed. Software commits them by writing the control word with its update bit set. The active copies then take the shadow values at the next period boundary, so a reconfiguration never cuts a period short. Starting a channel loads the shadow values at once and restarts its counter from zero.

Top module: `pwm_bank`

## Requirements
- R1: After reset every output is low and every mapped register reads as zero.
- R2: Channel n (n = 0..5) has its registers at byte address n*0x20 plus an offset: the control word at 0x00, the period at 0x08 and the first-phase count at 0x0C. The window ends at 0xB0. Any other address, including one that is not word aligned, reads as zero, and a write to it changes no register and no output.
- R3: The control word uses these bits: bit 0 runs the channel, bit 2 requests an update, bit 5 selects repeating operation, and bit 8 is the first-phase level. Reading the control word returns bits 0, 5 and 8 as last written, and bit 2 always reads as 0.
- R4: Reads of the period and first-phase registers return the shadow values last written. While a channel runs, a shadow write without an update request leaves its waveform unchanged.
- R5: A channel runs only while bit 0 and bit 5 are both 1. A stopped channel drives low. In the first cycle after it starts, the counter is at zero and the shadow values are already in use.
- R6: A running channel with period P and first-phase count D (0 < D < P) drives the first-phase level for D cycles, then its inverse for P−D cycles, and repeats.
- R7: A first-phase count of 0 makes the output the inverse of the first-phase level for the whole period. A count of P or more holds the output at the first-phase level for the whole period.
- R8: A period of 0 behaves as a period of one cycle.
- R9: After an update request, the shadow values take effect at the first period boundary after the write, and never in the middle of a period.
- R10: The bus is always ready. A read returns its data with rd_valid high in the cycle after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Register access request |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address within the window |
| bus_wdata | input | 32 | Write data |
| bus_ready | output | 1 | Access accepted (always 1) |
| rd_valid | output | 1 | Read data valid, one cycle after a read |
| rd_data | output | 32 | Read data |
| pwm_out | output | 6 | One output per channel |

## Verification
The embedded assertions check the following on every cycle:
- The counter never passes the last cycle of the active period.
- A zero period holds the counter at zero.
- A zero first-phase count gives the inverse level.
- The active values change only on a period boundary or while the channel is stopped.
- Each read is answered one cycle later.

The bench's scenarios cover the rest:
- The exact high and low runs of every channel, checked cycle by cycle against a scoreboard built from the requirements.
- The delay between an update request and the new period.
- The address decode, including unmapped and out-of-window accesses.
- The readback of shadow values and the self-clearing update bit.

// File: rtl/pwmb_pkg.sv
// Shared constants and types for the PWM bank.
// Assumes a byte-addressed window with one 32-byte block per channel.
package pwmb_pkg;
    localparam logic [4:0] OFF_CTRL = 5'h00;
    localparam logic [4:0] OFF_PER  = 5'h08;
    localparam logic [4:0] OFF_DUTY = 5'h0C;

    localparam int BIT_RUN  = 0;
    localparam int BIT_UPD  = 2;
    localparam int BIT_CONT = 5;
    localparam int BIT_LVL  = 8;

    typedef struct packed {
        logic run;
        logic cont;
        logic lvl;
    } ctrl_t;
endpackage

// File: rtl/pwmb_chan_regs.sv
// Per-channel register file: control bits and the shadow period and
// first-phase counts. Assumes the top has already decoded the address.
// The update request leaves as a single-cycle strobe.
module pwmb_chan_regs
    import pwmb_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_ctrl_i,
    input  logic          wr_per_i,
    input  logic          wr_duty_i,
    input  logic [DW-1:0] wdata_i,
    output ctrl_t         ctrl_o,
    output logic [DW-1:0] sh_per_o,
    output logic [DW-1:0] sh_duty_o,
    output logic          commit_o
);
    ctrl_t         ctrl_q;
    logic [DW-1:0] per_q, duty_q;

    // Hold the control bits and shadow counts written by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            per_q  <= '0;
            duty_q <= '0;
        end else begin
            if (wr_ctrl_i)
                ctrl_q <= '{run:  wdata_i[BIT_RUN],
                            cont: wdata_i[BIT_CONT],
                            lvl:  wdata_i[BIT_LVL]};
            if (wr_per_i)  per_q  <= wdata_i;
            if (wr_duty_i) duty_q <= wdata_i;
        end
    end

    // The update bit is never stored; it only raises a strobe.
    assign commit_o  = wr_ctrl_i & wdata_i[BIT_UPD];
    assign ctrl_o    = ctrl_q;
    assign sh_per_o  = per_q;
    assign sh_duty_o = duty_q;
endmodule

// File: rtl/pwmb_chan_core.sv
// Per-channel waveform engine: active period/first-phase registers, the
// cycle counter and the output level. Assumes run_i and lvl_i come straight
// from registers. While stopped, the active values follow the shadow values,
// so a start begins with them already in use.
module pwmb_chan_core #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_i,
    input  logic          lvl_i,
    input  logic [DW-1:0] sh_per_i,
    input  logic [DW-1:0] sh_duty_i,
    input  logic          commit_i,
    output logic          pwm_o
);
    logic [DW-1:0] cnt_q, act_per_q, act_duty_q;
    logic          pend_q;
    logic [DW-1:0] per_m1;
    logic          last;

    // Index of the final cycle in a period; a zero period acts as one cycle.
    assign per_m1 = (act_per_q == '0) ? '0 : act_per_q - 1'b1;
    assign last   = (cnt_q >= per_m1);

    // Advance the counter and move shadow values in at the period boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q      <= '0;
            act_per_q  <= '0;
            act_duty_q <= '0;
            pend_q     <= 1'b0;
        end else if (!run_i) begin
            cnt_q      <= '0;
            act_per_q  <= sh_per_i;
            act_duty_q <= sh_duty_i;
            pend_q     <= 1'b0;
        end else if (last) begin
            cnt_q  <= '0;
            pend_q <= commit_i;
            if (pend_q) begin
                act_per_q  <= sh_per_i;
                act_duty_q <= sh_duty_i;
            end
        end else begin
            cnt_q  <= cnt_q + 1'b1;
            pend_q <= pend_q | commit_i;
        end
    end

    // First phase drives lvl_i, the remainder its inverse; stopped drives low.
    assign pwm_o = run_i & ((cnt_q < act_duty_q) ? lvl_i : ~lvl_i);

    // R6
    cnt_in_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_i |-> cnt_q <= per_m1);
    // R9
    mid_period_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && cnt_q != '0) |-> ($stable(act_per_q) && $stable(act_duty_q)));
    // R8
    zero_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && act_per_q == '0) |-> cnt_q == '0);
    // R7
    zero_duty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && act_duty_q == '0) |-> pwm_o == ~lvl_i);
endmodule

// File: rtl/pwm_bank.sv
// Top of the PWM bank. Decodes the register bus, instantiates one register
// file and one waveform engine per channel, and returns read data one cycle
// after each read request. Assumes accesses are whole 32-bit words.
module pwm_bank
    import pwmb_pkg::*;
#(
    parameter int          NCH    = 6,
    parameter int          DW     = 32,
    parameter int          AW     = 8,
    parameter logic [7:0]  WINDOW = 8'hB0
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           bus_valid,
    input  logic           bus_write,
    input  logic [AW-1:0]  bus_addr,
    input  logic [DW-1:0]  bus_wdata,
    output logic           bus_ready,
    output logic           rd_valid,
    output logic [DW-1:0]  rd_data,
    output logic [NCH-1:0] pwm_out
);
    localparam int SLOT_LG = 5;
    localparam int IDX_W   = AW - SLOT_LG;

    logic [IDX_W-1:0]   chan_idx;
    logic [SLOT_LG-1:0] offs;
    logic               in_win;

    ctrl_t         ctrl_a  [NCH];
    logic [DW-1:0] sh_per_a [NCH];
    logic [DW-1:0] sh_dut_a [NCH];

    logic          rd_valid_q;
    logic [DW-1:0] rd_data_q, rd_next;

    assign chan_idx  = bus_addr[AW-1:SLOT_LG];
    assign offs      = bus_addr[SLOT_LG-1:0];
    assign in_win    = ({{(8 > AW ? 8 - AW : 0){1'b0}}, bus_addr} < WINDOW);
    assign bus_ready = 1'b1;

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        logic hit_w, commit;
        assign hit_w = bus_valid && bus_write && in_win && (int'(chan_idx) == g);

        pwmb_chan_regs #(.DW(DW)) regs_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_ctrl_i (hit_w && offs == OFF_CTRL),
            .wr_per_i  (hit_w && offs == OFF_PER),
            .wr_duty_i (hit_w && offs == OFF_DUTY),
            .wdata_i   (bus_wdata),
            .ctrl_o    (ctrl_a[g]),
            .sh_per_o  (sh_per_a[g]),
            .sh_duty_o (sh_dut_a[g]),
            .commit_o  (commit)
        );

        pwmb_chan_core #(.DW(DW)) core_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .run_i     (ctrl_a[g].run & ctrl_a[g].cont),
            .lvl_i     (ctrl_a[g].lvl),
            .sh_per_i  (sh_per_a[g]),
            .sh_duty_i (sh_dut_a[g]),
            .commit_i  (commit),
            .pwm_o     (pwm_out[g])
        );
    end

    // Select read data for the addressed register, zero when unmapped.
    always_comb begin
        rd_next = '0;
        for (int i = 0; i < NCH; i++) begin
            if (in_win && int'(chan_idx) == i) begin
                if (offs == OFF_CTRL) begin
                    rd_next[BIT_RUN]  = ctrl_a[i].run;
                    rd_next[BIT_CONT] = ctrl_a[i].cont;
                    rd_next[BIT_LVL]  = ctrl_a[i].lvl;
                end else if (offs == OFF_PER) begin
                    rd_next = sh_per_a[i];
                end else if (offs == OFF_DUTY) begin
                    rd_next = sh_dut_a[i];
                end
            end
        end
    end

    // Register the read response one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid_q <= 1'b0;
            rd_data_q  <= '0;
        end else begin
            rd_valid_q <= bus_valid & ~bus_write;
            rd_data_q  <= (bus_valid & ~bus_write) ? rd_next : '0;
        end
    end

    assign rd_valid = rd_valid_q;
    assign rd_data  = rd_data_q;

    // R10
    read_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write) |=> rd_valid);
    // R10
    no_spurious_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_valid && !bus_write) |=> !rd_valid);
endmodule

// File: tb/pwm_bank_tb_top.sv
// Scoreboard bench: a reference process predicts the output vector each
// cycle and queues it; a monitor pops and compares at the falling edge.
module pwm_bank_tb_top;
    localparam int N = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0, bus_write = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_ready, rd_valid;
    logic [31:0] rd_data;
    logic [N-1:0] pwm_out;

    int checks = 0, errors = 0;
    logic [N-1:0] exp_q[$];

    // Reference state per channel
    logic [31:0] m_sp[N], m_sd[N], m_ap[N], m_ad[N], m_cnt[N];
    bit          m_run[N], m_cont[N], m_lvl[N], m_pend[N];

    always #2 clk = ~clk;

    pwm_bank dut_i (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ready(bus_ready),
        .rd_valid(rd_valid), .rd_data(rd_data), .pwm_out(pwm_out)
    );

    // Reference model: next state from the requirements, then push expectation.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < N; c++) begin
                m_sp[c] = 0; m_sd[c] = 0; m_ap[c] = 0; m_ad[c] = 0; m_cnt[c] = 0;
                m_run[c] = 0; m_cont[c] = 0; m_lvl[c] = 0; m_pend[c] = 0;
            end
        end else begin
            logic [N-1:0] e;
            int  wc;
            bit  wr_ok;
            wr_ok = bus_valid && bus_write && bus_addr < 8'hB0
                    && int'(bus_addr[7:5]) < N;
            wc = int'(bus_addr[7:5]);
            for (int c = 0; c < N; c++) begin
                bit upd;
                logic [31:0] lastc;
                upd = wr_ok && wc == c && bus_addr[4:0] == 5'h00 && bus_wdata[2];
                lastc = (m_ap[c] == 0) ? 0 : m_ap[c] - 1;
                if (!(m_run[c] && m_cont[c])) begin
                    m_cnt[c] = 0; m_ap[c] = m_sp[c]; m_ad[c] = m_sd[c]; m_pend[c] = 0;
                end else if (m_cnt[c] >= lastc) begin
                    if (m_pend[c]) begin m_ap[c] = m_sp[c]; m_ad[c] = m_sd[c]; end
                    m_cnt[c] = 0; m_pend[c] = upd;
                end else begin
                    m_cnt[c] = m_cnt[c] + 1; m_pend[c] = m_pend[c] | upd;
                end
            end
            if (wr_ok) begin
                case (bus_addr[4:0])
                    5'h00: begin
                        m_run[wc] = bus_wdata[0]; m_cont[wc] = bus_wdata[5];
                        m_lvl[wc] = bus_wdata[8];
                    end
                    5'h08: m_sp[wc] = bus_wdata;
                    5'h0C: m_sd[wc] = bus_wdata;
                    default: ;
                endcase
            end
            for (int c = 0; c < N; c++)
                e[c] = (m_run[c] && m_cont[c]) ?
                       ((m_cnt[c] < m_ad[c]) ? m_lvl[c] : ~m_lvl[c]) : 1'b0;
            exp_q.push_back(e);
        end
    end

    // Monitor: compare every channel output once per cycle (R5 R6 R7 R8 R9).
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            logic [N-1:0] e;
            e = exp_q.pop_front();
            checks++;
            if (pwm_out !== e) begin
                errors++;
                $display("FAIL R6 waveform (R5 R7 R8 R9) t=%0t: got %b expected %b",
                         $time, pwm_out, e);
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_valid = 0; bus_write = 0;
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string req);
        @(posedge clk); #1;
        bus_valid = 1; bus_write = 0; bus_addr = a;
        @(posedge clk); #1;
        bus_valid = 0;
        checks++;
        if (rd_valid !== 1'b1 || rd_data !== exp) begin
            errors++;
            $display("FAIL %s read 0x%02h: got valid=%b data=0x%08h expected 0x%08h",
                     req, a, rd_valid, rd_data, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5) @(posedge clk);
        #1 rst_n = 1;
        // R1: reset state
        #1; checks++;
        if (pwm_out !== '0) begin
            errors++; $display("FAIL R1 outputs got %b expected 0", pwm_out);
        end
        rd_chk(8'h00, 32'h0, "R1");
        rd_chk(8'hA8, 32'h0, "R1");
        // R10: ready always high
        checks++;
        if (bus_ready !== 1'b1) begin
            errors++; $display("FAIL R10 bus_ready got %b expected 1", bus_ready);
        end

        // ch0: P=5 D=2 lvl=1 ; R4 readback
        wr(8'h08, 5); wr(8'h0C, 2);
        rd_chk(8'h08, 5, "R4");
        rd_chk(8'h0C, 2, "R4");
        wr(8'h00, 32'h125);
        rd_chk(8'h00, 32'h121, "R3");   // update bit reads 0
        // ch1: duty 0, lvl=1 -> static low (R7)
        wr(8'h28, 4); wr(8'h2C, 0); wr(8'h20, 32'h121);
        // ch2: duty >= period, lvl=1 -> static high (R7)
        wr(8'h48, 3); wr(8'h4C, 7); wr(8'h40, 32'h121);
        // ch3: period 0 (R8), duty 1, lvl=0
        wr(8'h68, 0); wr(8'h6C, 1); wr(8'h60, 32'h021);
        // ch4: lvl=0, P=6 D=2 (R6)
        wr(8'h88, 6); wr(8'h8C, 2); wr(8'h80, 32'h021);
        // ch5: run without repeat bit stays low (R5); registers at 0xA0 (R2)
        wr(8'hA8, 3); wr(8'hAC, 1); wr(8'hA0, 32'h101);
        rd_chk(8'hA8, 3, "R2");
        idle(40);

        // R4: shadow write without update leaves ch0 unchanged
        wr(8'h08, 8); wr(8'h0C, 3);
        idle(23);
        // R9: commit; takes effect at the next boundary
        wr(8'h00, 32'h125);
        idle(40);
        // R5: ch5 gets repeat bit now
        wr(8'hA0, 32'h121);
        idle(20);

        // R2: unmapped and out-of-window accesses
        wr(8'h04, 32'hFFFF_FFFF);
        rd_chk(8'h04, 32'h0, "R2");
        wr(8'hC8, 32'h55);
        rd_chk(8'hC8, 32'h0, "R2");
        wr(8'hB0, 32'h77);
        rd_chk(8'hB0, 32'h0, "R2");
        wr(8'h09, 32'h99);
        rd_chk(8'h09, 32'h0, "R2");
        rd_chk(8'h08, 8, "R2");
        rd_chk(8'hA8, 3, "R2");
        idle(10);

        // R5: stopping ch0 drives low
        wr(8'h00, 32'h0);
        idle(12);
        wait (exp_q.size() == 0);
        @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule